// File: doc/BRIEF.md
# UART Register and Command Controller

This block is the bus-facing control core of a simple byte-wide UART. A host reaches it through a 64-byte window with byte reads and writes. The window holds two mode registers that share one offset, a status register, a command port, the receive and transmit data ports, an interrupt status and mask pair, and two read-only baud bytes.

One command byte carries three independent fields: a miscellaneous action, a transmitter action and a receiver action. They are applied in that order, so a later field can undo an earlier one within the same byte. The controller does not hold the data path. It drives a receive FIFO and a transmit holder that sit beside it, through strobes and flags. It also combines its status bits into an interrupt status vector and drives one level interrupt line.

Top module: `uart_ctl_core`

## Requirements
- R1: After reset, status reads 0x08 (only transmit-empty set), both mode registers, the interrupt mask and the interrupt status read 0, `irq`, `tx_enable` and `rx_enable` are low, and the mode pointer selects mode register 0.
- R2: Offset 0x00 accesses the mode register that the pointer selects. A write stores into that register and then moves the pointer to register 1. A command byte with bits 6:4 equal to 1 moves the pointer back to register 0.
- R3: Command bits 3:2 control the transmitter and bits 1:0 the receiver: 1 enables, 2 disables, and 0 and 3 leave the enable unchanged. Status bit 2 (transmit-ready) equals the transmitter enable.
- R4: Command bits 6:4 equal to 2 disable the receiver and pulse `rxf_flush` for that cycle. A value of 3 disables the transmitter, sets transmit-empty and clears transmit-ready. The miscellaneous field is applied before the transmitter and receiver fields of the same byte.
- R5: A `brk_event` pulse sets interrupt status bit 2 (delta-break). Command bits 6:4 equal to 5 clear it. Values 0, 4, 6 and 7 change no state.
- R6: Status at offset 0x04 is {line_err[3:0], transmit-empty, transmit-ready, rxf_full, rxf_ready}, from bit 7 down to bit 0. Writes to 0x04 are ignored.
- R7: A write to offset 0x0C pulses `tx_load` with `tx_data` equal to the written byte and clears transmit-empty from the next cycle. A `tx_taken` pulse without a load sets it again.
- R8: A read of offset 0x0C returns `rxf_data` and pulses `rxf_pop` when `rxf_ready` is high. Otherwise it returns 0 and does not pop.
- R9: Interrupt status (read at 0x14) has bit 0 equal to transmit-ready, bit 1 equal to `rxf_full` when mode register 0 bit 6 is set and to `rxf_ready` otherwise, bit 2 equal to delta-break, and bits 7:3 zero.
- R10: A write to 0x14 sets the interrupt mask. `irq` is high exactly when interrupt status AND mask is non-zero.
- R11: Offset 0x18 reads `baud_div[15:8]` and 0x1C reads `baud_div[7:0]`. Offset 0x10 and all unmapped offsets read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 6 | Byte offset within the window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| rxf_ready | input | 1 | Receive FIFO holds at least one byte |
| rxf_full | input | 1 | Receive FIFO is full |
| rxf_data | input | 8 | Oldest byte in the receive FIFO |
| rxf_pop | output | 1 | Remove the oldest receive byte |
| rxf_flush | output | 1 | Empty the receive FIFO |
| rx_enable | output | 1 | Receiver enabled |
| tx_load | output | 1 | Load `tx_data` into the transmit holder |
| tx_data | output | 8 | Byte to transmit |
| tx_taken | input | 1 | Transmit holder has sent its byte |
| tx_enable | output | 1 | Transmitter enabled |
| line_err | input | 4 | {break, framing, parity, overrun} receive flags |
| brk_event | input | 1 | Pulse on a detected line break |
| baud_div | input | 16 | Baud divisor shown in the read-only bytes |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong enable or empty flag inside the block shows at the ports at once. It appears on `tx_enable`, `rx_enable` and `irq` in the cycle after the write that caused it, and in the status byte on the next read. A pointer error does not show on its own. It stays hidden until offset 0x00 is read or written again, so the stimulus mixes mode writes, pointer-reset commands and mode reads closely. A misdecoded command field can be masked by a later field of the same byte, so random command bytes are checked against a model that applies the three fields in order.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;
  localparam int DW = 8;
  localparam int AW = 6;

  localparam logic [AW-1:0] OFF_MODE = 6'h00;
  localparam logic [AW-1:0] OFF_STAT = 6'h04;
  localparam logic [AW-1:0] OFF_CMD  = 6'h08;
  localparam logic [AW-1:0] OFF_DATA = 6'h0C;
  localparam logic [AW-1:0] OFF_IPC  = 6'h10;
  localparam logic [AW-1:0] OFF_INT  = 6'h14;
  localparam logic [AW-1:0] OFF_BDH  = 6'h18;
  localparam logic [AW-1:0] OFF_BDL  = 6'h1C;

  localparam int ST_RXRDY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_TXRDY = 2;
  localparam int ST_TXEMP = 3;

  localparam int MR0_RXSEL = 6;

  typedef enum logic [2:0] {
    MISC_NOP   = 3'd0,
    MISC_PTR0  = 3'd1,
    MISC_RXRST = 3'd2,
    MISC_TXRST = 3'd3,
    MISC_ERRST = 3'd4,
    MISC_BRKCL = 3'd5,
    MISC_BRKON = 3'd6,
    MISC_BRKOF = 3'd7
  } misc_e;

  typedef struct packed {
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic brk_clr;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_act_t;
endpackage

// File: rtl/uart_ctl_cmd_dec.sv
module uart_ctl_cmd_dec
  import uart_ctl_pkg::*;
(
  input  logic          valid,
  input  logic [DW-1:0] cmd,
  output cmd_act_t      act
);
  misc_e misc;

  always_comb begin
    misc = misc_e'(cmd[6:4]);
    act  = '0;
    if (valid) begin
      act.ptr_rst = (misc == MISC_PTR0);
      act.rx_rst  = (misc == MISC_RXRST);
      act.tx_rst  = (misc == MISC_TXRST);
      act.brk_clr = (misc == MISC_BRKCL);
      act.tx_on   = (cmd[3:2] == 2'b01);
      act.tx_off  = (cmd[3:2] == 2'b10);
      act.rx_on   = (cmd[1:0] == 2'b01);
      act.rx_off  = (cmd[1:0] == 2'b10);
    end
  end
endmodule

// File: rtl/uart_ctl_mode_bank.sv
module uart_ctl_mode_bank #(
  parameter int N_MODE = 2,
  parameter int W      = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         ptr_rst,
  output logic [W-1:0] rd_val,
  output logic [W-1:0] mode0
);
  localparam int PW = (N_MODE > 1) ? $clog2(N_MODE) : 1;
  localparam logic [PW-1:0] PTR_LAST = PW'(N_MODE - 1);

  logic [PW-1:0] ptr_q, ptr_d;
  logic [W-1:0]  mr_arr [N_MODE];

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_rst)
      ptr_d = '0;
    else if (wr && ptr_q != PTR_LAST)
      ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < N_MODE; g++) begin : g_mr
    logic [W-1:0] q, d;
    logic         en;
    always_comb begin
      en = wr && (ptr_q == PW'(g));
      d  = en ? wdata : q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign mr_arr[g] = q;
  end

  assign rd_val = mr_arr[ptr_q];
  assign mode0  = mr_arr[0];
endmodule

// File: rtl/uart_ctl_irq.sv
module uart_ctl_irq
  import uart_ctl_pkg::*;
(
  input  logic [DW-1:0] status,
  input  logic          rx_sel_full,
  input  logic          dbrk,
  input  logic [DW-1:0] mask,
  output logic [DW-1:0] isr,
  output logic          irq
);
  always_comb begin
    isr    = '0;
    isr[0] = status[ST_TXRDY];
    isr[1] = rx_sel_full ? status[ST_FULL] : status[ST_RXRDY];
    isr[2] = dbrk;
    irq    = |(isr & mask);
  end
endmodule

// File: rtl/uart_ctl_core.sv
module uart_ctl_core
  import uart_ctl_pkg::*;
#(
  parameter int N_MODE  = 2,
  parameter int SYNC_ST = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rxf_ready,
  input  logic          rxf_full,
  input  logic [DW-1:0] rxf_data,
  output logic          rxf_pop,
  output logic          rxf_flush,
  output logic          rx_enable,
  output logic          tx_load,
  output logic [DW-1:0] tx_data,
  input  logic          tx_taken,
  output logic          tx_enable,
  input  logic [3:0]    line_err,
  input  logic          brk_event,
  input  logic [15:0]   baud_div,
  output logic          irq
);
  // reset: asynchronous assert, synchronous release
  logic [SYNC_ST-1:0] rst_pipe;
  logic               rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_ST-2:0], 1'b1};
  end
  assign rst_q = rst_pipe[SYNC_ST-1];

  logic wr_mode, wr_cmd, wr_data, wr_int, rd_data;
  always_comb begin
    wr_mode = bus_wr && (bus_addr == OFF_MODE);
    wr_cmd  = bus_wr && (bus_addr == OFF_CMD);
    wr_data = bus_wr && (bus_addr == OFF_DATA);
    wr_int  = bus_wr && (bus_addr == OFF_INT);
    rd_data = bus_rd && (bus_addr == OFF_DATA);
  end

  cmd_act_t act;
  uart_ctl_cmd_dec u_dec (
    .valid (wr_cmd),
    .cmd   (bus_wdata),
    .act   (act)
  );

  logic [DW-1:0] mode_rd, mode0;
  uart_ctl_mode_bank #(.N_MODE(N_MODE), .W(DW)) u_mode (
    .clk     (clk),
    .rst_n   (rst_q),
    .wr      (wr_mode),
    .wdata   (bus_wdata),
    .ptr_rst (act.ptr_rst),
    .rd_val  (mode_rd),
    .mode0   (mode0)
  );

  logic          tx_en_q, tx_en_d, rx_en_q, rx_en_d;
  logic          tx_emp_q, tx_emp_d, dbrk_q, dbrk_d;
  logic [DW-1:0] imr_q, imr_d;

  always_comb begin
    tx_en_d = tx_en_q;
    if (act.tx_rst) tx_en_d = 1'b0;
    if (act.tx_on)  tx_en_d = 1'b1;
    if (act.tx_off) tx_en_d = 1'b0;

    rx_en_d = rx_en_q;
    if (act.rx_rst) rx_en_d = 1'b0;
    if (act.rx_on)  rx_en_d = 1'b1;
    if (act.rx_off) rx_en_d = 1'b0;

    tx_emp_d = tx_emp_q;
    if (act.tx_rst)    tx_emp_d = 1'b1;
    if (wr_data)       tx_emp_d = 1'b0;
    else if (tx_taken) tx_emp_d = 1'b1;

    dbrk_d = dbrk_q;
    if (act.brk_clr) dbrk_d = 1'b0;
    if (brk_event)   dbrk_d = 1'b1;

    imr_d = wr_int ? bus_wdata : imr_q;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      tx_en_q  <= 1'b0;
      rx_en_q  <= 1'b0;
      tx_emp_q <= 1'b1;
      dbrk_q   <= 1'b0;
      imr_q    <= '0;
    end else begin
      tx_en_q  <= tx_en_d;
      rx_en_q  <= rx_en_d;
      tx_emp_q <= tx_emp_d;
      dbrk_q   <= dbrk_d;
      imr_q    <= imr_d;
    end
  end

  logic [DW-1:0] status, isr;
  assign status = {line_err, tx_emp_q, tx_en_q, rxf_full, rxf_ready};

  uart_ctl_irq u_irq (
    .status      (status),
    .rx_sel_full (mode0[MR0_RXSEL]),
    .dbrk        (dbrk_q),
    .mask        (imr_q),
    .isr         (isr),
    .irq         (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        OFF_MODE: bus_rdata = mode_rd;
        OFF_STAT: bus_rdata = status;
        OFF_DATA: bus_rdata = rxf_ready ? rxf_data : '0;
        OFF_INT:  bus_rdata = isr;
        OFF_BDH:  bus_rdata = baud_div[15:8];
        OFF_BDL:  bus_rdata = baud_div[7:0];
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign rxf_pop   = rd_data && rxf_ready;
  assign rxf_flush = act.rx_rst;
  assign rx_enable = rx_en_q;
  assign tx_enable = tx_en_q;
  assign tx_load   = wr_data;
  assign tx_data   = bus_wdata;
endmodule

// File: rtl/uart_ctl_chk.sv
module uart_ctl_chk
  import uart_ctl_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          tx_taken,
  input logic          tx_emp_q,
  input logic          tx_enable,
  input logic          rxf_pop,
  input logic          rxf_ready,
  input logic          brk_event,
  input logic          dbrk_q,
  input logic [DW-1:0] imr_q,
  input logic          irq
);
  // R7
  load_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_DATA) |=> !tx_emp_q);
  // R7
  taken_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_taken && !(bus_wr && bus_addr == OFF_DATA)) |=> tx_emp_q);
  // R8
  pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_pop |-> rxf_ready);
  // R10
  mask_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imr_q == '0) |-> !irq);
  // R3
  tx_enable_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_CMD && bus_wdata[3:2] == 2'b01) |=> tx_enable);
  // R4
  tx_reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_CMD && bus_wdata[6:4] == 3'd3 && bus_wdata[3:2] != 2'b01)
    |=> (!tx_enable && tx_emp_q));
  // R5
  break_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_event |=> dbrk_q);
endmodule

bind uart_ctl_core uart_ctl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .tx_taken  (tx_taken),
  .tx_emp_q  (tx_emp_q),
  .tx_enable (tx_enable),
  .rxf_pop   (rxf_pop),
  .rxf_ready (rxf_ready),
  .brk_event (brk_event),
  .dbrk_q    (dbrk_q),
  .imr_q     (imr_q),
  .irq       (irq)
);

// File: tb/uart_ctl_core_test.sv
`timescale 1ns/1ps
module uart_ctl_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       rxf_ready = 0, rxf_full = 0;
  logic [7:0] rxf_data = '0;
  logic       rxf_pop, rxf_flush, rx_enable, tx_load, tx_enable, irq;
  logic [7:0] tx_data;
  logic       tx_taken = 0, brk_event = 0;
  logic [3:0] line_err = '0;
  logic [15:0] baud_div = 16'hA55A;

  uart_ctl_core uut (.*);

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0;

  // bench model
  logic [7:0] m_mr0 = 0, m_mr1 = 0, m_imr = 0;
  logic       m_ptr = 0, m_txen = 0, m_rxen = 0, m_txemp = 1, m_dbrk = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_status();
    return {line_err, m_txemp, m_txen, rxf_full, rxf_ready};
  endfunction

  function automatic logic [7:0] m_isr();
    logic [7:0] v = '0;
    v[0] = m_txen;
    v[1] = m_mr0[6] ? rxf_full : rxf_ready;
    v[2] = m_dbrk;
    return v;
  endfunction

  function automatic logic [7:0] m_read(logic [5:0] a);
    case (a)
      6'h00: return m_ptr ? m_mr1 : m_mr0;
      6'h04: return m_status();
      6'h0C: return rxf_ready ? rxf_data : 8'h00;
      6'h14: return m_isr();
      6'h18: return baud_div[15:8];
      6'h1C: return baud_div[7:0];
      default: return 8'h00;
    endcase
  endfunction

  function automatic void m_write(logic [5:0] a, logic [7:0] d);
    case (a)
      6'h00: begin if (m_ptr) m_mr1 = d; else m_mr0 = d; m_ptr = 1; end
      6'h08: begin
        case (d[6:4])
          3'd1: m_ptr = 0;
          3'd2: m_rxen = 0;
          3'd3: begin m_txen = 0; m_txemp = 1; end
          3'd5: m_dbrk = 0;
          default: ;
        endcase
        if (d[3:2] == 2'd1) m_txen = 1;
        if (d[3:2] == 2'd2) m_txen = 0;
        if (d[1:0] == 2'd1) m_rxen = 1;
        if (d[1:0] == 2'd2) m_rxen = 0;
      end
      6'h0C: m_txemp = 0;
      6'h14: m_imr = d;
      default: ;
    endcase
  endfunction

  task automatic bwrite(logic [5:0] a, logic [7:0] d);
    logic fl, ld; logic [7:0] td;
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    #1; fl = rxf_flush; ld = tx_load; td = tx_data;
    chk("R4 flush pulse", fl, (a == 6'h08) && (d[6:4] == 3'd2));
    chk("R7 load pulse", ld, a == 6'h0C);
    if (a == 6'h0C) chk("R7 load data", td, d);
    @(posedge clk);
    m_write(a, d);
    @(negedge clk);
    bus_wr = 0;
    if (a == 6'h08 && d[6:4] == 3'd2) begin rxf_ready = 0; rxf_full = 0; end
  endtask

  task automatic bread(logic [5:0] a, string req);
    logic [7:0] v; logic p;
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    #1; v = bus_rdata; p = rxf_pop;
    chk(req, v, m_read(a));
    chk("R8 pop strobe", p, (a == 6'h0C) && rxf_ready);
    @(posedge clk);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(posedge clk);
    @(negedge clk); s = 0;
  endtask

  task automatic outs_chk();
    #1;
    chk("R10 irq level", irq, |(m_isr() & m_imr));
    chk("R3 tx_enable", tx_enable, m_txen);
    chk("R3 rx_enable", rx_enable, m_rxen);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset state
    bread(6'h04, "R1 status reset");
    bread(6'h14, "R1 isr reset");
    bread(6'h00, "R1 mode reset");
    outs_chk();

    // R2 pointer sequence
    bwrite(6'h00, 8'h11); bwrite(6'h00, 8'h22); bwrite(6'h00, 8'h33);
    bread(6'h00, "R2 mode1 after writes");
    chk("R2 mode1 value", m_mr1, 8'h33);
    bwrite(6'h08, 8'h10);
    bread(6'h00, "R2 mode0 after ptr reset");

    // R4 ordering: misc 3 then tx enable
    bwrite(6'h08, 8'h35); outs_chk();
    bread(6'h04, "R4 status after misc3+enable");
    bwrite(6'h08, 8'h3C); outs_chk();   // misc3, tx reserved
    bread(6'h04, "R4 misc3 clears tx");

    // R9 receive source select
    bwrite(6'h08, 8'h10);
    bwrite(6'h00, 8'h40);
    rxf_ready = 1; rxf_full = 0; rxf_data = 8'h5C;
    bread(6'h14, "R9 isr full-select");
    bwrite(6'h08, 8'h10); bwrite(6'h00, 8'h00);
    bread(6'h14, "R9 isr ready-select");
    bread(6'h0C, "R8 rx data read");
    rxf_ready = 0;
    bread(6'h0C, "R8 empty read zero");

    // R11 unmapped, R6 ignored writes
    bwrite(6'h10, 8'hFF); bwrite(6'h04, 8'hFF); bwrite(6'h3F, 8'hFF);
    bread(6'h10, "R11 ipc read zero");
    bread(6'h3F, "R11 unmapped zero");
    bread(6'h18, "R11 baud high");
    bread(6'h1C, "R11 baud low");
    bread(6'h04, "R6 status after ignored writes");

    // R5 break
    pulse(brk_event); m_dbrk = 1;
    bwrite(6'h14, 8'h04); outs_chk();
    bwrite(6'h08, 8'h40); outs_chk();
    bread(6'h14, "R5 misc4 no effect");
    bwrite(6'h08, 8'h50); outs_chk();
    bread(6'h14, "R5 misc5 clears break");

    for (int i = 0; i < 400; i++) begin
      int op = $urandom % 8;
      logic [7:0] d = 8'($urandom);
      case (op)
        0: bwrite(6'h00, d);
        1: bwrite(6'h08, d);
        2: bwrite(6'h14, d);
        3: bwrite(6'h0C, d);
        4: begin
          logic [5:0] a;
          case ($urandom % 9)
            0: a = 6'h00; 1: a = 6'h04; 2: a = 6'h0C; 3: a = 6'h10;
            4: a = 6'h14; 5: a = 6'h18; 6: a = 6'h1C; 7: a = 6'h08;
            default: a = 6'($urandom);
          endcase
          bread(a, "R6 R9 random read");
        end
        5: begin pulse(tx_taken); m_txemp = 1; end
        6: begin pulse(brk_event); m_dbrk = 1; end
        default: begin
          @(negedge clk);
          rxf_ready = d[0]; rxf_full = d[0] & d[1];
          line_err = d[7:4]; rxf_data = 8'($urandom);
        end
      endcase
      outs_chk();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule